// File: doc/BRIEF.md
# SPI Banked Register Command Decoder

This block is an SPI slave that turns one-byte commands into accesses to a banked file of 8-bit control registers. Each command is framed by one low period of the active-low chip select. The first byte of a command carries an operation and a register address. The operation reads, writes, sets bits in or clears bits in a register of the selected bank. Four reserved command bytes instead stream bytes to or from an external buffer memory, or clear the whole register file. The Ethernet logic that would normally sit behind the registers is not part of the block, so every register is plain storage.

The register space has four banks of 32 addresses. The top five addresses are shared by all banks. The last of them holds the bank number in its two low bits, so a host switches banks by writing that register. Some registers are in a slow class: a read of one of them answers with a padding byte first and the real value after it. Buffer traffic leaves the block over a simple strobe interface. Read data is expected one system clock after the read strobe.

SCK, MOSI and chip select are sampled with the system clock. SCK must therefore be much slower than the system clock.

Top module: `spi_banked_regs`

## Requirements
- R1: The first byte after chip select falls is a command sent MSB first: bits 7:5 are the operation and bits 4:0 are the register address. Operation 000 reads. The register value is returned on MISO during the next byte. Input is sampled on the rising SCK edge and MISO changes on the falling edge (SPI mode 0).
- R2: Operation 010 stores the byte that follows the command in the addressed register. Any further bytes in the same chip-select period are ignored.
- R3: Operation 100 ORs the following byte into the register. Operation 101 clears the register bits that are 1 in the following byte.
- R4: Bits 1:0 of register 0x1F select the bank. Addresses 0x00 to 0x1A are separate in each bank. Addresses 0x1B to 0x1F reach the same five registers from every bank.
- R5: Slow-class registers are, in bank 2, addresses 0x00 to 0x1A and, in bank 3, addresses 0x00 to 0x05 and 0x0A. A read of one of them returns 0x00 in the first byte after the command and the register value in the second byte.
- R6: Operations 100 and 101 on a slow-class register leave it unchanged.
- R7: Command byte 0x3A streams buffer bytes out on MISO, one per SPI byte, from consecutive addresses. The start address is bank-0 register 0x00 (low eight bits) joined with the low BUF_AW-8 bits of bank-0 register 0x01. The address wraps from the top of the buffer to 0.
- R8: Command byte 0x7A turns each following byte into one write strobe at consecutive addresses. The start address is formed from bank-0 registers 0x02 and 0x03 in the same way, with the same wrap. Read and write strobes are never active together.
- R9: Command byte 0xFF clears every register to zero, which also selects bank 0.
- R10: MISO is 0 while chip select is high and during the command byte. Raising chip select ends the command at once, and a partly shifted byte has no effect.
- R11: After reset every register reads as zero, MISO is 0 and no buffer strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| mem_rd | output | 1 | One-cycle buffer read strobe |
| mem_wr | output | 1 | One-cycle buffer write strobe |
| mem_addr | output | BUF_AW | Buffer address for the strobe |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data, valid the cycle after mem_rd |

## Verification
The assertions assume that each SCK level lasts at least six system clocks, so that a falling edge is never seen before the response byte has been loaded. They also assume that chip select never changes in the same system clock as an SCK edge, and that buffer read data arrives one cycle after the strobe. The stimulus holds each SCK level for eight system clocks and moves SCK, MOSI and chip select only on falling system-clock edges, a full half period apart. The memory model answers one cycle after each read strobe with a value computed from the address.

// File: rtl/spirb_pkg.sv
package spirb_pkg;
   localparam int BYTE_W   = 8;
   localparam int REG_AW   = 5;
   localparam int BANK_W   = 2;
   localparam int OP_W     = 3;
   localparam logic [REG_AW-1:0] SHARED_BASE = 5'h1B;
   localparam logic [REG_AW-1:0] BANK_REG    = 5'h1F;

   localparam logic [BYTE_W-1:0] CMD_BUF_RD = 8'h3A;
   localparam logic [BYTE_W-1:0] CMD_BUF_WR = 8'h7A;
   localparam logic [BYTE_W-1:0] CMD_SRST   = 8'hFF;

   localparam logic [OP_W-1:0] OPC_READ  = 3'b000;
   localparam logic [OP_W-1:0] OPC_WRITE = 3'b010;
   localparam logic [OP_W-1:0] OPC_SET   = 3'b100;
   localparam logic [OP_W-1:0] OPC_CLR   = 3'b101;

   typedef enum logic [1:0] {RF_WR, RF_SET, RF_CLR} rf_op_e;

   typedef enum logic [2:0] {
      ST_CMD, ST_RD, ST_WR, ST_SET, ST_CLR, ST_BRD, ST_BWR, ST_IDLE
   } cmd_st_e;

   // registers that answer with a padding byte before their value
   function automatic logic is_slow(input logic [BANK_W-1:0] b,
                                    input logic [REG_AW-1:0] a);
      return (b == 2'd2 && a <= 5'h1A) ||
             (b == 2'd3 && (a <= 5'h05 || a == 5'h0A));
   endfunction
endpackage

// File: rtl/spirb_sync.sv
module spirb_sync #(
   parameter int WIDTH = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spirb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spirb_shift.sv
module spirb_shift
   import spirb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_n_s,
   input  logic              mosi_s,
   input  logic [BYTE_W-1:0] tx_load,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              miso
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic              sck_q, rise, fall, miso_r;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh;

   assign rise = sck_s & ~sck_q;
   assign fall = ~sck_s & sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q    <= 1'b0;
         bit_cnt  <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         rx_byte  <= '0;
         byte_vld <= 1'b0;
         miso_r   <= 1'b0;
      end else begin
         sck_q    <= sck_s;
         byte_vld <= 1'b0;
         if (cs_n_s) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
            miso_r  <= 1'b0;
         end else begin
            if (rise) begin
               rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                  byte_vld <= 1'b1;
                  rx_byte  <= {rx_sh[BYTE_W-2:0], mosi_s};
               end
            end
            if (fall) begin
               if (bit_cnt == '0) {miso_r, tx_sh} <= {tx_load, 1'b0};
               else               {miso_r, tx_sh} <= {tx_sh, 1'b0};
            end
         end
      end
   end

   assign miso = miso_r;

   // R10: deselected slave drives MISO low
   p_miso_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !miso);

   // R1: a complete byte is only reported right after a sampling edge
   p_byte_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(rise));
endmodule

// File: rtl/spirb_regfile.sv
module spirb_regfile
   import spirb_pkg::*;
#(
   parameter int NBANK  = 4,
   parameter int BUF_AW = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              op_vld,
   input  rf_op_e            op_kind,
   input  logic [BANK_W-1:0] op_bank,
   input  logic [REG_AW-1:0] op_addr,
   input  logic [BYTE_W-1:0] op_data,
   input  logic [BANK_W-1:0] rd_bank,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   output logic [BANK_W-1:0] bank_sel,
   output logic [BUF_AW-1:0] rd_base,
   output logic [BUF_AW-1:0] wr_base
);
   localparam int DEPTH = NBANK * (1 << REG_AW);
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (NBANK != (1 << BANK_W)) begin : g_bad_banks
         $error("spirb_regfile: NBANK must match the two-bit bank field");
      end
   endgenerate

   logic [BYTE_W-1:0] rf [DEPTH];
   logic [IDX_W-1:0]  op_idx, rd_idx;
   logic              op_blocked;

   function automatic logic [IDX_W-1:0] map_idx(input logic [BANK_W-1:0] b,
                                                input logic [REG_AW-1:0] a);
      return (a >= SHARED_BASE) ? IDX_W'(a) : IDX_W'({b, a});
   endfunction

   assign op_idx     = map_idx(op_bank, op_addr);
   assign rd_idx     = map_idx(rd_bank, rd_addr);
   assign op_blocked = (op_kind != RF_WR) && is_slow(op_bank, op_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) rf[i] <= '0;
      end else if (soft_rst) begin
         for (int i = 0; i < DEPTH; i++) rf[i] <= '0;
      end else if (op_vld && !op_blocked) begin
         case (op_kind)
            RF_WR:   rf[op_idx] <= op_data;
            RF_SET:  rf[op_idx] <= rf[op_idx] | op_data;
            RF_CLR:  rf[op_idx] <= rf[op_idx] & ~op_data;
            default: rf[op_idx] <= rf[op_idx];
         endcase
      end
   end

   assign rd_data  = rf[rd_idx];
   assign bank_sel = rf[IDX_W'(BANK_REG)][BANK_W-1:0];

   generate
      if (BUF_AW == BYTE_W) begin : g_base_narrow
         assign rd_base = rf[0];
         assign wr_base = rf[2];
      end else begin : g_base_wide
         assign rd_base = {rf[1][BUF_AW-BYTE_W-1:0], rf[0]};
         assign wr_base = {rf[3][BUF_AW-BYTE_W-1:0], rf[2]};
      end
   endgenerate

   // R9: soft reset lands in bank 0
   p_srst_bank0_r9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (bank_sel == '0));

   // R6: bit operations on slow-class registers leave them untouched
   p_slow_bitop_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && !soft_rst && op_kind != RF_WR && is_slow(op_bank, op_addr))
      |=> (rf[$past(op_idx)] == $past(rf[op_idx])));
endmodule

// File: rtl/spi_banked_regs.sv
module spi_banked_regs
   import spirb_pkg::*;
#(
   parameter int BUF_AW      = 13,
   parameter int NBANK       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [BUF_AW-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata
);
   generate
      if (BUF_AW < BYTE_W || BUF_AW > 2 * BYTE_W) begin : g_bad_aw
         $error("spi_banked_regs: BUF_AW must lie between 8 and 16");
      end
   endgenerate

   logic [2:0]        sync_q;
   logic              cs_n_s, sck_s, mosi_s;
   logic              byte_vld;
   logic [BYTE_W-1:0] rx_byte, tx_load;

   spirb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({spi_cs_n, spi_sck, spi_mosi}), .q(sync_q));
   assign {cs_n_s, sck_s, mosi_s} = sync_q;

   spirb_shift u_shift (
      .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
      .tx_load(tx_load), .byte_vld(byte_vld), .rx_byte(rx_byte), .miso(spi_miso));

   cmd_st_e           state;
   logic [BANK_W-1:0] cur_bank, rd_bank, bank_sel;
   logic [REG_AW-1:0] cur_addr, rd_addr;
   logic [BYTE_W-1:0] rd_data, op_data;
   logic [BUF_AW-1:0] ptr, rd_base, wr_base;
   logic              op_vld, soft_rst, rd_pend;
   rf_op_e            op_kind;
   logic [OP_W-1:0]   opcode;

   assign opcode  = rx_byte[BYTE_W-1 -: OP_W];
   assign rd_bank = (state == ST_CMD) ? bank_sel : cur_bank;
   assign rd_addr = (state == ST_CMD) ? rx_byte[REG_AW-1:0] : cur_addr;

   spirb_regfile #(.NBANK(NBANK), .BUF_AW(BUF_AW)) u_rf (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .op_vld(op_vld),
      .op_kind(op_kind), .op_bank(cur_bank), .op_addr(cur_addr), .op_data(op_data),
      .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data),
      .bank_sel(bank_sel), .rd_base(rd_base), .wr_base(wr_base));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_CMD;
         cur_bank  <= '0;
         cur_addr  <= '0;
         ptr       <= '0;
         tx_load   <= '0;
         rd_pend   <= 1'b0;
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         op_vld    <= 1'b0;
         op_kind   <= RF_WR;
         op_data   <= '0;
         soft_rst  <= 1'b0;
      end else begin
         mem_rd   <= 1'b0;
         mem_wr   <= 1'b0;
         op_vld   <= 1'b0;
         soft_rst <= 1'b0;
         rd_pend  <= mem_rd;
         if (rd_pend) tx_load <= mem_rdata;
         if (cs_n_s) begin
            state   <= ST_CMD;
            tx_load <= '0;
         end else if (byte_vld) begin
            case (state)
               ST_CMD: begin
                  cur_bank <= bank_sel;
                  cur_addr <= rx_byte[REG_AW-1:0];
                  if (rx_byte == CMD_SRST) begin
                     soft_rst <= 1'b1;
                     state    <= ST_IDLE;
                  end else if (rx_byte == CMD_BUF_RD) begin
                     mem_rd   <= 1'b1;
                     mem_addr <= rd_base;
                     ptr      <= rd_base + 1'b1;
                     state    <= ST_BRD;
                  end else if (rx_byte == CMD_BUF_WR) begin
                     ptr   <= wr_base;
                     state <= ST_BWR;
                  end else begin
                     case (opcode)
                        OPC_READ: begin
                           tx_load <= is_slow(bank_sel, rx_byte[REG_AW-1:0]) ? '0 : rd_data;
                           state   <= ST_RD;
                        end
                        OPC_WRITE: state <= ST_WR;
                        OPC_SET:   state <= ST_SET;
                        OPC_CLR:   state <= ST_CLR;
                        default:   state <= ST_IDLE;
                     endcase
                  end
               end
               ST_RD: tx_load <= rd_data;
               ST_WR, ST_SET, ST_CLR: begin
                  op_vld  <= 1'b1;
                  op_data <= rx_byte;
                  op_kind <= (state == ST_WR) ? RF_WR : (state == ST_SET) ? RF_SET : RF_CLR;
                  state   <= ST_IDLE;
               end
               ST_BRD: begin
                  mem_rd   <= 1'b1;
                  mem_addr <= ptr;
                  ptr      <= ptr + 1'b1;
               end
               ST_BWR: begin
                  mem_wr    <= 1'b1;
                  mem_addr  <= ptr;
                  mem_wdata <= rx_byte;
                  ptr       <= ptr + 1'b1;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R8: the buffer port never reads and writes in the same cycle
   p_mem_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R7: each buffer read is a single-cycle strobe
   p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   // R10: nothing is shifted out while the command byte arrives
   p_cmd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CMD && !rd_pend) |-> (tx_load == '0));
endmodule

// File: tb/tb_spi_banked_regs.sv
`timescale 1ns/1ps
module tb_spi_banked_regs;
   localparam int BUF_AW = 13;
   localparam int T_HALF = 32;
   localparam int WD_NS  = 200000 * 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic spi_miso, mem_rd, mem_wr;
   logic [BUF_AW-1:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata;

   always #2 clk = ~clk;

   spi_banked_regs #(.BUF_AW(BUF_AW)) dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   function automatic logic [7:0] memf(input int a);
      return 8'(a) ^ 8'(a >> 8) ^ 8'hC3;
   endfunction

   // buffer memory model: data one cycle after the strobe
   always @(posedge clk) mem_rdata <= mem_rd ? memf(int'(mem_addr)) : 8'h00;

   int log_n;
   int log_a [64];
   int log_d [64];
   always @(negedge clk) if (mem_wr && log_n < 64) begin
      log_a[log_n] = int'(mem_addr);
      log_d[log_n] = int'(mem_wdata);
      log_n++;
   end

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [7:0] sh [128];

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int ridx(int b, int a);
      return (a >= 27) ? a : b * 32 + a;
   endfunction
   function automatic bit slow(int b, int a);
      return (b == 2 && a <= 26) || (b == 3 && (a <= 5 || a == 10));
   endfunction
   function automatic int bank();
      return int'(sh[31][1:0]);
   endfunction

   task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - n; i--) begin
         spi_mosi = tx[i];
         #(T_HALF);
         rx[i] = spi_miso;
         spi_sck = 1'b1;
         #(T_HALF);
         spi_sck = 1'b0;
      end
   endtask

   task automatic sel();
      spi_cs_n = 1'b0;
      #(T_HALF);
   endtask
   task automatic desel();
      #(T_HALF);
      spi_cs_n = 1'b1;
      spi_mosi = 1'b0;
      #(3 * T_HALF);
   endtask

   task automatic reg_rd(input int a, input string req);
      logic [7:0] r;
      int b, e;
      b = bank();
      e = int'(sh[ridx(b, a)]);
      sel();
      spi_bits({3'b000, 5'(a)}, 8, r);
      chk("R10 quiet command byte", int'(r), 0);
      spi_bits(8'h00, 8, r);
      if (slow(b, a)) begin
         chk({req, " R5 padding byte"}, int'(r), 0);
         spi_bits(8'h00, 8, r);
         chk({req, " R5 value after padding"}, int'(r), e);
      end else begin
         chk(req, int'(r), e);
      end
      desel();
   endtask

   // opc: 2 write, 4 set, 5 clear
   task automatic reg_op(input int opc, input int a, input logic [7:0] d);
      logic [7:0] r;
      int b, i;
      b = bank();
      i = ridx(b, a);
      sel();
      spi_bits({3'(opc), 5'(a)}, 8, r);
      spi_bits(d, 8, r);
      desel();
      if (opc == 2) sh[i] = d;
      else if (!slow(b, a)) sh[i] = (opc == 4) ? (sh[i] | d) : (sh[i] & ~d);
   endtask

   task automatic soft_reset();
      logic [7:0] r;
      sel();
      spi_bits(8'hFF, 8, r);
      desel();
      for (int i = 0; i < 128; i++) sh[i] = 8'h00;
   endtask

   task automatic buf_rd(input int n, input string req);
      logic [7:0] r;
      int base;
      base = (int'(sh[1]) * 256 + int'(sh[0])) & ((1 << BUF_AW) - 1);
      sel();
      spi_bits(8'h3A, 8, r);
      for (int k = 0; k < n; k++) begin
         spi_bits(8'h00, 8, r);
         chk(req, int'(r), int'(memf((base + k) & ((1 << BUF_AW) - 1))));
      end
      desel();
   endtask

   task automatic buf_wr(input int n);
      logic [7:0] r;
      logic [7:0] d;
      int base;
      int exp_d [16];
      base = (int'(sh[3]) * 256 + int'(sh[2])) & ((1 << BUF_AW) - 1);
      log_n = 0;
      sel();
      spi_bits(8'h7A, 8, r);
      for (int k = 0; k < n; k++) begin
         d = 8'($urandom);
         exp_d[k] = int'(d);
         spi_bits(d, 8, r);
      end
      desel();
      chk("R8 strobe count", log_n, n);
      for (int k = 0; k < n && k < log_n; k++) begin
         chk("R8 write address", log_a[k], (base + k) & ((1 << BUF_AW) - 1));
         chk("R8 write data", log_d[k], exp_d[k]);
      end
   endtask

   initial begin
      #(WD_NS);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      int k, a;
      logic [7:0] d;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 128; i++) sh[i] = 8'h00;
      log_n = 0;
      repeat (10) @(posedge clk);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);

      // R11 reset state
      chk("R11 miso after reset", int'(spi_miso), 0);
      chk("R11 no read strobe", int'(mem_rd), 0);
      chk("R11 no write strobe", int'(mem_wr), 0);
      reg_rd(31, "R11 bank register zero");
      reg_rd(7, "R11 register zero");

      // R1 / R2 write then read, extra bytes ignored
      reg_op(2, 5, 8'hA5);
      reg_rd(5, "R1 read back");
      sel();
      spi_bits({3'b010, 5'd6}, 8, r);
      spi_bits(8'h3C, 8, r);
      spi_bits(8'h99, 8, r);
      desel();
      sh[6] = 8'h3C;
      reg_rd(6, "R2 later bytes ignored");

      // R3 set / clear
      reg_op(2, 9, 8'h0F);
      reg_op(4, 9, 8'h30);
      reg_rd(9, "R3 bit set");
      reg_op(5, 9, 8'h05);
      reg_rd(9, "R3 bit clear");

      // R4 banking and shared addresses
      reg_op(2, 31, 8'h01);
      reg_op(2, 5, 8'h11);
      reg_op(2, 27, 8'h77);
      reg_op(2, 31, 8'h00);
      reg_rd(5, "R4 bank 0 separate");
      reg_rd(27, "R4 shared from bank 0");
      reg_op(2, 31, 8'h01);
      reg_rd(5, "R4 bank 1 separate");

      // R5 / R6 slow class
      reg_op(2, 31, 8'h02);
      reg_op(2, 3, 8'h0F);
      reg_rd(3, "R5 bank 2 slow read");
      reg_op(4, 3, 8'hF0);
      reg_rd(3, "R6 set ignored");
      reg_op(5, 3, 8'h0F);
      reg_rd(3, "R6 clear ignored");
      reg_rd(28, "R4 shared not slow in bank 2");
      reg_op(2, 31, 8'h03);
      reg_op(2, 10, 8'h5C);
      reg_rd(10, "R5 bank 3 addr 0x0A");
      reg_op(2, 6, 8'h21);
      reg_op(4, 6, 8'h80);
      reg_rd(6, "R3 set on normal bank 3 register");

      // R7 buffer read with wrap
      reg_op(2, 31, 8'h00);
      reg_op(2, 0, 8'hFE);
      reg_op(2, 1, 8'h1F);
      buf_rd(5, "R7 stream with wrap");
      reg_op(2, 1, 8'hE2);
      buf_rd(4, "R7 upper pointer bits masked");

      // R8 buffer write, plain and wrapping
      reg_op(2, 2, 8'h10);
      reg_op(2, 3, 8'h04);
      buf_wr(6);
      reg_op(2, 2, 8'hFF);
      reg_op(2, 3, 8'hFF);
      buf_wr(3);

      // R10 aborted commands
      reg_op(2, 8, 8'h33);
      sel();
      spi_bits({3'b010, 5'd8}, 8, r);
      spi_bits(8'hCC, 5, r);
      desel();
      reg_rd(8, "R10 partial data byte dropped");
      sel();
      spi_bits(8'hFF, 4, r);
      desel();
      reg_rd(8, "R10 partial command dropped");

      // random traffic
      for (int it = 0; it < 150; it++) begin
         k = int'($urandom % 8);
         a = int'($urandom % 32);
         d = 8'($urandom);
         case (k)
            3: reg_op(2, a, d);
            4: reg_op(4, a, d);
            5: reg_op(5, a, d);
            6: reg_op(2, 31, 8'($urandom % 4));
            default: reg_rd(a, "R1 random read");
         endcase
      end

      // R9 soft reset
      reg_op(2, 31, 8'h03);
      reg_op(2, 4, 8'h09);
      reg_op(2, 29, 8'hAB);
      soft_reset();
      reg_rd(31, "R9 bank back to 0");
      reg_rd(29, "R9 shared cleared");
      reg_op(2, 31, 8'h03);
      reg_rd(4, "R9 bank 3 cleared");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule